// File: doc/BRIEF.md
# Word-Level Triple Modular Redundancy Voter

Three identical units run the same operation at the same time. This block takes their result words together under one shared valid strobe and compares the whole words. If at least two words match, the matching word goes out one cycle later and execution continues. When exactly two words match, the block also names the odd replica in a sticky fault mask and raises a one-cycle disagreement pulse. When all three words differ, no replica can be trusted, so no result is emitted and a sticky halt is raised.

The halt stays set until reset or until the clear input is pulsed. A replica that is already marked faulty still takes part in every vote. A saturating counter records how many two-to-one disagreements have occurred. The block does not repair or resynchronize a faulty replica.

Top module: `tmr_word_voter`

## Requirements
- R1: When all three words are equal on an accepted strobe, `vote_word` carries that word with `vote_valid` high on the next cycle, `mismatch_pulse` stays low and `fault_mask` does not change.
- R2: When exactly two words are equal, `vote_word` carries the agreed word with `vote_valid` high on the next cycle.
- R3: When exactly two words are equal, the mask bit of the odd replica is set and `mismatch_pulse` is high for exactly that one output cycle. The bit mapping is bit 0 = A, bit 1 = B and bit 2 = C.
- R4: Mask bits are sticky. Only reset or `clear_i` clears them. A marked replica is still compared, and its bit stays set when it later agrees.
- R5: When all three words differ, `halt` rises on the next cycle. In that cycle `vote_valid` and `mismatch_pulse` are low and `fault_mask` is unchanged.
- R6: While `halt` is high it stays high, and strobes are ignored: `vote_valid` stays low, and `vote_word`, `fault_mask` and `mismatch_count` do not change.
- R7: A cycle with `clear_i` high clears `halt` and `fault_mask` on the next edge. That cycle's strobe is ignored, so `vote_valid` is low afterwards. `mismatch_count` is kept.
- R8: A cycle without `in_valid` gives `vote_valid` low on the next cycle and leaves `vote_word` holding its last value.
- R9: `mismatch_count` adds one for each two-to-one disagreement and saturates at its all-ones value.
- R10: After reset, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clear_i | input | 1 | Releases halt and clears the fault mask |
| in_valid | input | 1 | The three replica words are valid |
| word_a | input | W | Replica A result |
| word_b | input | W | Replica B result |
| word_c | input | W | Replica C result |
| vote_word | output | W | Voted result word |
| vote_valid | output | 1 | `vote_word` is new this cycle |
| fault_mask | output | 3 | Sticky faulty-replica flags (bit 0 = A, bit 1 = B, bit 2 = C) |
| mismatch_pulse | output | 1 | A two-to-one disagreement was voted this cycle |
| halt | output | 1 | Sticky halt after a three-way disagreement |
| mismatch_count | output | CW | Saturating count of two-to-one disagreements |

## Verification
Every output comes from a single register stage. Each result is therefore due exactly one cycle after the strobe that caused it: the voted word, the valid flag, the pulse, the mask update, the halt and the count step. The bench drives each stimulus on a falling edge, lets exactly one rising edge pass, and samples on the next falling edge. Each check therefore looks at the cycle where the result first appears. For the ignored-strobe and clear cases, the same sample shows that the state held or was released.

// File: rtl/tmr_word_voter.sv
module tmr_word_voter #(
  parameter int W  = 32,
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear_i,
  input  logic          in_valid,
  input  logic [W-1:0]  word_a,
  input  logic [W-1:0]  word_b,
  input  logic [W-1:0]  word_c,
  output logic [W-1:0]  vote_word,
  output logic          vote_valid,
  output logic [2:0]    fault_mask,
  output logic          mismatch_pulse,
  output logic          halt,
  output logic [CW-1:0] mismatch_count
);

  localparam logic [CW-1:0] CNT_MAX = '1;

  logic eq_ab, eq_ac, eq_bc, all_eq, none_eq, take;
  logic [2:0]   odd_one;
  logic [W-1:0] agreed;

  assign eq_ab   = (word_a == word_b);
  assign eq_ac   = (word_a == word_c);
  assign eq_bc   = (word_b == word_c);
  assign all_eq  = eq_ab & eq_ac;
  assign none_eq = ~eq_ab & ~eq_ac & ~eq_bc;
  assign take    = in_valid & ~halt & ~clear_i;
  assign agreed  = eq_bc ? word_b : word_a;

  always_comb begin
    odd_one = 3'b000;
    if (!all_eq) begin
      if (eq_ab)      odd_one = 3'b100;
      else if (eq_ac) odd_one = 3'b010;
      else if (eq_bc) odd_one = 3'b001;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vote_word      <= '0;
      vote_valid     <= 1'b0;
      fault_mask     <= 3'b000;
      mismatch_pulse <= 1'b0;
      halt           <= 1'b0;
      mismatch_count <= '0;
    end else begin
      vote_valid     <= 1'b0;
      mismatch_pulse <= 1'b0;
      if (clear_i) begin
        halt       <= 1'b0;
        fault_mask <= 3'b000;
      end else if (take) begin
        if (none_eq) begin
          halt <= 1'b1;
        end else begin
          vote_word  <= agreed;
          vote_valid <= 1'b1;
          if (odd_one != 3'b000) begin
            fault_mask     <= fault_mask | odd_one;
            mismatch_pulse <= 1'b1;
            if (mismatch_count != CNT_MAX)
              mismatch_count <= mismatch_count + 1'b1;
          end
        end
      end
    end
  end

endmodule

// File: rtl/tmr_word_voter_chk.sv
module tmr_word_voter_chk #(
  parameter int W  = 32,
  parameter int CW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          clear_i,
  input logic          in_valid,
  input logic [W-1:0]  word_a,
  input logic [W-1:0]  word_b,
  input logic [W-1:0]  word_c,
  input logic [W-1:0]  vote_word,
  input logic          vote_valid,
  input logic [2:0]    fault_mask,
  input logic          mismatch_pulse,
  input logic          halt,
  input logic [CW-1:0] mismatch_count
);

  a_r1_unanimous_out: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !halt && !clear_i && word_a == word_b && word_b == word_c)
    |=> (vote_valid && !mismatch_pulse && vote_word == $past(word_a)));

  a_r3_pulse_with_fault: assert property (@(posedge clk) disable iff (!rst_n)
    mismatch_pulse |-> (vote_valid && fault_mask != 3'b000));

  a_r4_mask_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !clear_i |=> ((fault_mask & $past(fault_mask)) == $past(fault_mask)));

  a_r6_halt_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (halt && !clear_i) |=> halt);

  a_r6_no_valid_halted: assert property (@(posedge clk) disable iff (!rst_n)
    halt |-> !vote_valid);

  a_r7_clear_releases: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (!halt && fault_mask == 3'b000 && !vote_valid));

  a_r9_count_saturates: assert property (@(posedge clk) disable iff (!rst_n)
    (&mismatch_count) |=> (&mismatch_count));

endmodule

bind tmr_word_voter tmr_word_voter_chk #(.W(W), .CW(CW)) u_chk (.*);

// File: tb/tmr_word_voter_test.sv
module tmr_word_voter_test;
  localparam int W  = 8;
  localparam int CW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clear_i = 1'b0;
  logic in_valid = 1'b0;
  logic [W-1:0] word_a = '0, word_b = '0, word_c = '0;
  logic [W-1:0] vote_word;
  logic vote_valid, mismatch_pulse, halt;
  logic [2:0] fault_mask;
  logic [CW-1:0] mismatch_count;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  tmr_word_voter #(.W(W), .CW(CW)) uut (.*);

  // {a, b, c, expected word, pulse, mask, count}
  localparam logic [39:0] VEC [5] = '{
    {8'h11, 8'h11, 8'h11, 8'h11, 1'b0, 3'b000, 4'd0},
    {8'h22, 8'h22, 8'h23, 8'h22, 1'b1, 3'b100, 4'd1},
    {8'h30, 8'h31, 8'h30, 8'h30, 1'b1, 3'b110, 4'd2},
    {8'h44, 8'h45, 8'h45, 8'h45, 1'b1, 3'b111, 4'd3},
    {8'h55, 8'h55, 8'h55, 8'h55, 1'b0, 3'b111, 4'd3}
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(logic v, logic [W-1:0] a, logic [W-1:0] b,
                      logic [W-1:0] c, logic clr);
    @(negedge clk);
    in_valid = v; word_a = a; word_b = b; word_c = c; clear_i = clr;
    @(negedge clk);
    in_valid = 1'b0; clear_i = 1'b0;
  endtask

  initial begin
    #2;
    check("R10 word", vote_word, 0);
    check("R10 valid", vote_valid, 0);
    check("R10 mask", fault_mask, 0);
    check("R10 halt", halt, 0);
    check("R10 count", mismatch_count, 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < 5; i++) begin
      step(1'b1, VEC[i][39:32], VEC[i][31:24], VEC[i][23:16], 1'b0);
      check("R1/R2 word", vote_word, VEC[i][15:8]);
      check("R1/R2 valid", vote_valid, 1);
      check("R3 pulse", mismatch_pulse, VEC[i][7]);
      check("R3/R4 mask", fault_mask, VEC[i][6:4]);
      check("R9 count", mismatch_count, VEC[i][3:0]);
    end

    step(1'b0, 8'h66, 8'h66, 8'h66, 1'b0);
    check("R8 valid low", vote_valid, 0);
    check("R8 word held", vote_word, 8'h55);

    step(1'b1, 8'h01, 8'h02, 8'h03, 1'b0);
    check("R5 halt", halt, 1);
    check("R5 valid", vote_valid, 0);
    check("R5 pulse", mismatch_pulse, 0);
    check("R5 mask", fault_mask, 3'b111);

    step(1'b1, 8'h77, 8'h77, 8'h78, 1'b0);
    check("R6 halt held", halt, 1);
    check("R6 valid", vote_valid, 0);
    check("R6 word", vote_word, 8'h55);
    check("R6 count", mismatch_count, 3);

    step(1'b1, 8'h99, 8'h99, 8'h99, 1'b1);
    check("R7 halt", halt, 0);
    check("R7 mask", fault_mask, 0);
    check("R7 valid", vote_valid, 0);
    check("R7 count", mismatch_count, 3);

    step(1'b1, 8'h99, 8'h99, 8'h99, 1'b0);
    check("R7 resume", vote_valid, 1);
    check("R7 resume word", vote_word, 8'h99);

    step(1'b1, 8'hA0, 8'hA1, 8'hA1, 1'b0);
    check("R3 odd A", fault_mask, 3'b001);
    check("R2 agreed B/C", vote_word, 8'hA1);
    for (int k = 0; k < 14; k++) step(1'b1, 8'h05, 8'h05, 8'h06, 1'b0);
    check("R9 saturate", mismatch_count, 15);
    check("R9 mask", fault_mask, 3'b101);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule